// File: doc/BRIEF.md
# Least-Recently-Served Matrix Arbiter

This block picks one winner per cycle from a set of requesters that compete for a single shared resource. Each winner goes to the back of the line. Priority is held as one bit per unordered pair of requesters. The bit records which member of the pair was served less recently.

A grant goes to the requester that no other active requester outranks. When a grant is issued, the winner loses every pairwise comparison, so it drops to the bottom of the order. No other pair's relative order changes. A requester that keeps asking therefore waits at most one grant behind each of the others.

The block has two parameters. `NUM_REQ` sets the number of requesters. `ORDER` sets the priority order after reset: lower indices first, or higher indices first. The enable input gates arbitration for the cycle. Grants come out through a register, one clock after the request and enable that produced them.

Top module: `lrs_matrix_arb`

## Requirements
- R1: While `rst` is high at a clock edge, `gnt` is all zeros after that edge. With `ORDER` = ORDER_LOW_FIRST, the first grant after reset with all requesters active goes to index 0.
- R2: `gnt` never has more than one bit set.
- R3: Any bit set in `gnt` was also set in `req` on the preceding clock edge.
- R4: If `en` is high and `req` is non-zero at an edge, `gnt` has exactly one bit set after that edge.
- R5: If `en` is low or `req` is zero at an edge, `gnt` is all zeros after that edge.
- R6: The grant goes to the active requester served least recently. Requesters never served since reset are ranked by the reset order.
- R7: A requester granted at one edge is not granted at the next edge if any other requester is active then.
- R8: An edge that issues no grant leaves the priority order unchanged. Requests presented while `en` is low have no effect on later winners.
- R9: With `ORDER` = ORDER_HIGH_FIRST, three requesters, and all three requesting continuously, the grants go to index 2, then 1, then 0.
- R10: A lone active requester is granted on every enabled edge, whatever the priority order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_REQ | Request vector, bit i for requester i |
| en | input | 1 | Arbitration enable for the current edge |
| gnt | output | NUM_REQ | Registered one-hot grant, or zero |

## Verification
The assertions check the following on every cycle:
- the grant is zero or one-hot;
- the grant is drawn from the previous edge's requests;
- a grant appears whenever requests are enabled, and none appears otherwise;
- a winner never repeats back to back while others wait.

Some properties depend on history over many cycles. These are:
- the full least-recently-served ordering;
- the effect of the reset order;
- the order being preserved across disabled or idle cycles.

Only the bench's reference queue, compared on every clock under directed and pseudo-random patterns, can show these. A second instance with reversed reset order covers the three-requester 2-1-0 sequence.

// File: rtl/lrs_arb_pkg.sv
package lrs_arb_pkg;

  // Priority order loaded into the matrix by reset.
  typedef enum logic {
    ORDER_LOW_FIRST  = 1'b0,  // lower index outranks higher index
    ORDER_HIGH_FIRST = 1'b1   // higher index outranks lower index
  } prio_order_e;

endpackage

// File: rtl/lrs_prio_matrix.sv
// Pairwise priority state. Only pairs with i < j are stored.
// beats[i*N+j] = 1 means requester i outranks requester j.
module lrs_prio_matrix
  import lrs_arb_pkg::*;
#(
  parameter int          N     = 4,
  parameter prio_order_e ORDER = ORDER_LOW_FIRST
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           upd,
  input  logic [N-1:0]   win,
  output logic [N*N-1:0] beats
);

  localparam logic RST_BIT = (ORDER == ORDER_LOW_FIRST);

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i < j) begin : g_pair
        logic w_q;

        always_ff @(posedge clk) begin
          if (rst) begin
            w_q <= RST_BIT;
          end else if (upd) begin
            if (win[i]) begin
              w_q <= 1'b0;      // winner i falls below j
            end else if (win[j]) begin
              w_q <= 1'b1;      // winner j falls below i
            end
          end
        end

        assign beats[i*N+j] = w_q;
        assign beats[j*N+i] = ~w_q;
      end else if (i == j) begin : g_diag
        assign beats[i*N+j] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/lrs_grant_net.sv
// Combinational grant: a requester wins when no active requester outranks it.
module lrs_grant_net #(
  parameter int N = 4
) (
  input  logic [N-1:0]   req,
  input  logic [N*N-1:0] beats,
  output logic [N-1:0]   gnt
);

  for (genvar j = 0; j < N; j++) begin : g_tgt
    logic [N-1:0] over_j;   // over_j[i]: i outranks j

    for (genvar i = 0; i < N; i++) begin : g_src
      assign over_j[i] = beats[i*N+j];
    end

    assign gnt[j] = req[j] & ~|(req & over_j);
  end

endmodule

// File: rtl/lrs_matrix_arb.sv
module lrs_matrix_arb
  import lrs_arb_pkg::*;
#(
  parameter int          NUM_REQ = 4,
  parameter prio_order_e ORDER   = ORDER_LOW_FIRST
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req,
  input  logic               en,
  output logic [NUM_REQ-1:0] gnt
);

  localparam int PAIRS_W = NUM_REQ * NUM_REQ;

  logic [PAIRS_W-1:0] beats;
  logic [NUM_REQ-1:0] gnt_c;
  logic               upd;
  logic [NUM_REQ-1:0] gnt_q;

  lrs_grant_net #(.N(NUM_REQ)) u_net (
    .req   (req),
    .beats (beats),
    .gnt   (gnt_c)
  );

  assign upd = en & (|gnt_c);

  lrs_prio_matrix #(.N(NUM_REQ), .ORDER(ORDER)) u_mtx (
    .clk   (clk),
    .rst   (rst),
    .upd   (upd),
    .win   (gnt_c),
    .beats (beats)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q <= '0;
    end else if (en) begin
      gnt_q <= gnt_c;
    end else begin
      gnt_q <= '0;
    end
  end

  assign gnt = gnt_q;

endmodule

// File: rtl/lrs_arb_checker.sv
module lrs_arb_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic         en,
  input logic [N-1:0] gnt
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (gnt == '0));

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  p_from_req_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((gnt & ~$past(req)) == '0));

  p_grant_issued_r4: assert property (@(posedge clk) disable iff (rst)
    (en && (req != '0)) |=> ($countones(gnt) == 1));

  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!en || (req == '0)) |=> (gnt == '0));

  for (genvar k = 0; k < N; k++) begin : g_rep
    localparam logic [N-1:0] SELF = N'(1) << k;
    p_no_repeat_r7: assert property (@(posedge clk) disable iff (rst)
      (gnt[k] && en && ((req & ~SELF) != '0)) |=> !gnt[k]);
  end

endmodule

bind lrs_matrix_arb lrs_arb_checker #(.N(NUM_REQ)) u_lrs_chk (
  .clk (clk),
  .rst (rst),
  .req (req),
  .en  (en),
  .gnt (gnt)
);

// File: tb/test_lrs_matrix_arb.sv
`timescale 1ns/1ps
module test_lrs_matrix_arb;
  import lrs_arb_pkg::*;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic         en  = 1'b0;
  logic [N-1:0] gnt;

  logic [2:0]   req_r = '0;
  logic         en_r  = 1'b0;
  logic [2:0]   gnt_r;

  int checks   = 0;
  int failures = 0;
  int order[$];

  always #2 clk = ~clk;

  lrs_matrix_arb #(.NUM_REQ(N), .ORDER(ORDER_LOW_FIRST)) i_lrs_matrix_arb (
    .clk (clk), .rst (rst), .req (req), .en (en), .gnt (gnt)
  );

  lrs_matrix_arb #(.NUM_REQ(3), .ORDER(ORDER_HIGH_FIRST)) i_lrs_matrix_arb_rev (
    .clk (clk), .rst (rst), .req (req_r), .en (en_r), .gnt (gnt_r)
  );

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: gnt=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference: queue of indices, most deserving first.
  task automatic model_reset();
    order.delete();
    for (int i = 0; i < N; i++) order.push_back(i);
  endtask

  task automatic model_step(input logic [N-1:0] r, input logic e, output logic [N-1:0] exp);
    int idx;
    exp = '0;
    if (e) begin
      for (int p = 0; p < order.size(); p++) begin
        if (r[order[p]]) begin
          idx = order[p];
          exp[idx] = 1'b1;
          order.delete(p);
          order.push_back(idx);
          break;
        end
      end
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic e, input string tag);
    logic [N-1:0] exp;
    req = r;
    en  = e;
    model_step(r, e, exp);
    @(negedge clk);
    check(gnt, exp, tag);
  endtask

  task automatic rev_step(input logic [2:0] exp, input string tag);
    req_r = 3'b111;
    en_r  = 1'b1;
    @(negedge clk);
    check({1'b0, gnt_r}, {1'b0, exp}, tag);
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog: run hung, gnt=%b expected=completion", gnt);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    model_reset();
    req = 4'b1111;
    en  = 1'b1;
    repeat (3) @(negedge clk);
    check(gnt, '0, "R1 reset holds grant low");
    check({1'b0, gnt_r}, '0, "R1 reset holds rev grant low");
    rst = 1'b0;

    // R1/R6/R7: all active, rotate 0,1,2,3,0
    step(4'b1111, 1'b1, "R1 first grant index 0");
    step(4'b1111, 1'b1, "R7 rotate to 1");
    step(4'b1111, 1'b1, "R6 rotate to 2");
    step(4'b1111, 1'b1, "R6 rotate to 3");
    step(4'b1111, 1'b1, "R6 wrap to 0");

    // R5: no requests, then enable low
    step(4'b0000, 1'b1, "R5 no requests");
    step(4'b1010, 1'b0, "R5 enable low");
    step(4'b0110, 1'b0, "R8 enable low no update");
    // R8: order must continue as if the disabled cycles never happened
    step(4'b1110, 1'b1, "R8 order kept after disabled cycles");
    step(4'b0000, 1'b1, "R8 idle no update");
    step(4'b1110, 1'b1, "R8 order kept after idle");

    // R10: lone requester repeated
    step(4'b1000, 1'b1, "R10 lone requester");
    step(4'b1000, 1'b1, "R10 lone requester again");
    step(4'b0001, 1'b1, "R10 other lone requester");
    step(4'b0001, 1'b1, "R10 other lone requester again");

    // R6/R7: mixed patterns
    step(4'b1001, 1'b1, "R7 pair alternates");
    step(4'b1001, 1'b1, "R7 pair alternates back");
    step(4'b0110, 1'b1, "R6 least recent of 1,2");
    step(4'b0111, 1'b1, "R6 least recent of 0,1,2");

    // R6: pseudo-random patterns
    lf = 16'hACE1;
    for (int c = 0; c < 400; c++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[3:0], |lf[6:5], "R6 pseudo-random");
    end

    // R9: reversed reset order, three requesters
    req = '0;
    en  = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    rev_step(3'b100, "R9 rev first grant 2");
    rev_step(3'b010, "R9 rev then 1");
    rev_step(3'b001, "R9 rev then 0");
    rev_step(3'b100, "R9 rev back to 2");
    en_r = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule